// File: doc/BRIEF.md
# UART Interrupt Identification and Status Word

This block collects the interrupt causes of a serial port and packs them, together with the modem-line and line-condition bytes, into one 32-bit status word that a host reads in a single access. An active-low pending flag and a 3-bit cause code at the bottom of the word tell the host which handler to run. The causes are, from highest to lowest priority: a sticky receive error, receive data available, receive character timeout, transmit space available, and a modem-line change.

The same block holds the port's configuration word. From it come the four per-cause enables, the modem-control outputs, a loopback switch, a receive flow-control flag and the line-control fields for word length, stop bits and parity. In loopback the modem inputs are fed from the block's own modem-control outputs. Error detection in the receiver and the FIFOs themselves lie outside; their conditions arrive as single-cycle pulses or as levels.

Top module: `uart_irq_status`

## Requirements
- R1: status bit 0 is 0 when a cause is pending and 1 when none is. With nothing pending, bits 3:1 read 0.
- R2: bits 3:1 carry the code of the single highest-priority enabled cause: sticky receive error 3, receive data available 2, character timeout 6, transmit space 1, modem change 0. The priority runs in that order.
- R3: configuration bits 0 (receive: gates both data available and timeout), 1 (transmit space), 2 (receive error) and 3 (modem change) enable the causes. A disabled cause neither sets the pending flag nor shows a code.
- R4: status bits 11:8 are the change flags and bits 15:12 the inverted levels of CTS, DSR, RI and DCD, in that order. A change flag sets when its level changes. A status read clears it, except that a change in the same cycle as the read keeps it set.
- R5: status bits 23:16 are data ready 0, overrun 1, parity 2, framing 3, break 4, holding empty 5, transmitter empty 6 and receive FIFO error 7. Bits 1-4 and 7 are sticky until a status read; a pulse in the read cycle stays set. Bits 0, 5 and 6 follow their inputs. Any sticky bit is the receive-error cause.
- R6: configuration bit 28 selects loopback. In loopback CTS follows RTS, DSR follows DTR, RI follows OUT1 and DCD follows OUT2, and the external modem inputs are ignored.
- R7: configuration bits 24 DTR, 25 RTS, 26 OUT1, 27 OUT2, 28 loopback and 29 receive flow control drive their outputs. Bits 9:8 give the word-length code (0 means 5 bits, 3 means 8 bits), bit 10 selects two stop bits, bit 11 enables parity and bit 12 selects even parity.
- R8: the status word reflects the inputs one clock after they are sampled. Bits 7:4 and 31:24 read 0.
- R9: after reset the status word is 0x0000F001 and all configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| stat_rd_i | input | 1 | Status read strobe; the host samples status_o in this cycle |
| cts_i | input | 1 | Clear-to-send input, active high |
| dsr_i | input | 1 | Data-set-ready input, active high |
| ri_i | input | 1 | Ring indicator input, active high |
| dcd_i | input | 1 | Carrier detect input, active high |
| rx_avail_i | input | 1 | Receive FIFO at or above its trigger level |
| char_tmo_i | input | 1 | Receive character timeout |
| tx_space_i | input | 1 | Transmit FIFO has space |
| rx_ready_i | input | 1 | Receive data ready level |
| overrun_i | input | 1 | Overrun pulse |
| parity_err_i | input | 1 | Parity error pulse |
| frame_err_i | input | 1 | Framing error pulse |
| break_i | input | 1 | Break detected pulse |
| thr_empty_i | input | 1 | Holding register empty level |
| tx_idle_i | input | 1 | Transmitter fully empty level |
| rx_fifo_err_i | input | 1 | Receive FIFO error pulse |
| status_o | output | 32 | Packed status word |
| dtr_o | output | 1 | DTR output |
| rts_o | output | 1 | RTS output |
| out1_o | output | 1 | OUT1 output |
| out2_o | output | 1 | OUT2 output |
| loop_o | output | 1 | Loopback selected |
| rx_flow_o | output | 1 | Receive flow control enabled |
| word_len_o | output | 2 | Word-length code |
| two_stop_o | output | 1 | Two stop bits |
| parity_en_o | output | 1 | Parity enabled |
| parity_even_o | output | 1 | Even parity |

## Verification
The assertions check on every cycle that an idle word carries code 0, that a pending code is one of the five legal values, and that a pending enabled receive error always wins. They also check that sticky error bits and change flags survive until a read and that a quiet read clears them, and that in loopback the levels track the modem-control outputs. The bench shows what no single-cycle property covers. It sweeps every combination of the five causes against all sixteen enable patterns, and it checks the exact bit placement of each modem and line flag. It also covers a change or pulse that lands in the same cycle as a read, and the decoding of every configuration field.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STAT_W  = 32;
  localparam int MDM_W   = 4;   // CTS, DSR, RI, DCD
  localparam int LSR_W   = 8;
  localparam int ERR_W   = 5;   // overrun, parity, framing, break, fifo error
  localparam int ID_W    = 3;
  localparam int IEN_W   = 4;
  localparam int LCR_W   = 5;
  localparam int MCR_W   = 6;
  localparam int LCR_LSB = 8;
  localparam int MCR_LSB = 24;

  typedef enum logic [ID_W-1:0] {
    ID_MODEM   = 3'd0,
    ID_TXSPACE = 3'd1,
    ID_RXDATA  = 3'd2,
    ID_RXERR   = 3'd3,
    ID_TIMEOUT = 3'd6
  } irq_id_e;
endpackage

// File: rtl/uart_modem_status.sv
module uart_modem_status #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ext_i,
  input  logic [N-1:0] lb_i,
  input  logic         loop_i,
  input  logic         clr_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] delta_o
);
  logic [N-1:0] eff;
  logic [N-1:0] lvl_q, delta_q;

  assign eff = loop_i ? lb_i : ext_i;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[g]   <= 1'b0;
        delta_q[g] <= 1'b0;
      end else begin
        lvl_q[g]   <= eff[g];
        delta_q[g] <= (delta_q[g] & ~clr_i) | (eff[g] ^ lvl_q[g]);
      end
    end
  end

  assign lvl_o   = lvl_q;
  assign delta_o = delta_q;

  p_delta_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && eff == lvl_q) |=> delta_q == '0);
  p_delta_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff != lvl_q) |=> ((delta_q & $past(eff ^ lvl_q)) == $past(eff ^ lvl_q)));
  p_loop_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |=> lvl_q == $past(lb_i));
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             dr_i,
  input  logic             thre_i,
  input  logic             temt_i,
  input  logic [ERR_W-1:0] err_i,   // {fifo, break, framing, parity, overrun}
  output logic [LSR_W-1:0] lsr_o,
  output logic             err_o
);
  logic [2:0]       lvl_q;
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      err_q <= '0;
    end else begin
      lvl_q <= {temt_i, thre_i, dr_i};
      err_q <= (err_q & {ERR_W{~clr_i}}) | err_i;
    end
  end

  assign lsr_o = {err_q[4], lvl_q[2], lvl_q[1], err_q[3:0], lvl_q[0]};
  assign err_o = |err_q;

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_q & $past(err_q)) == $past(err_q));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && err_i == '0) |=> err_q == '0);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [IEN_W-1:0] en_i,   // {modem, rxerr, txspace, rx}
  input  logic             err_req_i,
  input  logic             rx_req_i,
  input  logic             tmo_req_i,
  input  logic             tx_req_i,
  input  logic             ms_req_i,
  output logic             pend_no,
  output logic [ID_W-1:0]  id_o
);
  irq_id_e id;

  always_comb begin
    pend_no = 1'b0;
    id      = ID_MODEM;
    if (en_i[2] && err_req_i)      id = ID_RXERR;
    else if (en_i[0] && rx_req_i)  id = ID_RXDATA;
    else if (en_i[0] && tmo_req_i) id = ID_TIMEOUT;
    else if (en_i[1] && tx_req_i)  id = ID_TXSPACE;
    else if (en_i[3] && ms_req_i)  id = ID_MODEM;
    else                           pend_no = 1'b1;
  end

  assign id_o = id;
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [STAT_W-1:0] cfg_wdata_i,
  input  logic              stat_rd_i,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  input  logic              rx_avail_i,
  input  logic              char_tmo_i,
  input  logic              tx_space_i,
  input  logic              rx_ready_i,
  input  logic              overrun_i,
  input  logic              parity_err_i,
  input  logic              frame_err_i,
  input  logic              break_i,
  input  logic              thr_empty_i,
  input  logic              tx_idle_i,
  input  logic              rx_fifo_err_i,
  output logic [STAT_W-1:0] status_o,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic              loop_o,
  output logic              rx_flow_o,
  output logic [1:0]        word_len_o,
  output logic              two_stop_o,
  output logic              parity_en_o,
  output logic              parity_even_o
);
  logic [IEN_W-1:0] ien_q;
  logic [LCR_W-1:0] lcr_q;
  logic [MCR_W-1:0] mcr_q;
  logic [2:0]       src_q;   // {timeout, rx avail, tx space}

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      src_q <= '0;
    end else begin
      src_q <= {char_tmo_i, rx_avail_i, tx_space_i};
      if (cfg_we_i) begin
        ien_q <= cfg_wdata_i[IEN_W-1:0];
        lcr_q <= cfg_wdata_i[LCR_LSB +: LCR_W];
        mcr_q <= cfg_wdata_i[MCR_LSB +: MCR_W];
      end
    end
  end

  // mcr_q: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loop, 5 rx flow
  logic [MDM_W-1:0] mdm_lvl, mdm_delta, mdm_lb;
  assign mdm_lb = {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]};

  uart_modem_status #(.N(MDM_W)) u_modem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ext_i   ({dcd_i, ri_i, dsr_i, cts_i}),
    .lb_i    (mdm_lb),
    .loop_i  (mcr_q[4]),
    .clr_i   (stat_rd_i),
    .lvl_o   (mdm_lvl),
    .delta_o (mdm_delta)
  );

  logic [LSR_W-1:0] lsr;
  logic             line_err;

  uart_line_status u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stat_rd_i),
    .dr_i   (rx_ready_i),
    .thre_i (thr_empty_i),
    .temt_i (tx_idle_i),
    .err_i  ({rx_fifo_err_i, break_i, frame_err_i, parity_err_i, overrun_i}),
    .lsr_o  (lsr),
    .err_o  (line_err)
  );

  logic            pend_n;
  logic [ID_W-1:0] id;

  uart_irq_prio u_prio (
    .en_i      (ien_q),
    .err_req_i (line_err),
    .rx_req_i  (src_q[1]),
    .tmo_req_i (src_q[2]),
    .tx_req_i  (src_q[0]),
    .ms_req_i  (|mdm_delta),
    .pend_no   (pend_n),
    .id_o      (id)
  );

  assign status_o = {8'h00, lsr, ~mdm_lvl, mdm_delta, 4'h0, id, pend_n};

  assign dtr_o         = mcr_q[0];
  assign rts_o         = mcr_q[1];
  assign out1_o        = mcr_q[2];
  assign out2_o        = mcr_q[3];
  assign loop_o        = mcr_q[4];
  assign rx_flow_o     = mcr_q[5];
  assign word_len_o    = lcr_q[1:0];
  assign two_stop_o    = lcr_q[2];
  assign parity_en_o   = lcr_q[3];
  assign parity_even_o = lcr_q[4];

  p_idle_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> status_o[3:1] == 3'd0);
  p_legal_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[0] |-> (status_o[3:1] inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}));
  p_err_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q[2] && line_err) |-> status_o[3:0] == 4'b0110);
  p_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> status_o[0]);
endmodule

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        stat_rd = 1'b0;
  logic [3:0]  mdm_in = '0;    // {dcd, ri, dsr, cts}
  logic        rx_avail = 1'b0, char_tmo = 1'b0, tx_space = 1'b0;
  logic [7:0]  lsr_in = '0;    // same bit order as the line byte
  logic [31:0] status;
  logic dtr, rts, out1, out2, loopb, rx_flow, two_stop, par_en, par_even;
  logic [1:0] word_len;

  uart_irq_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .stat_rd_i(stat_rd), .cts_i(mdm_in[0]), .dsr_i(mdm_in[1]), .ri_i(mdm_in[2]),
    .dcd_i(mdm_in[3]), .rx_avail_i(rx_avail), .char_tmo_i(char_tmo),
    .tx_space_i(tx_space), .rx_ready_i(lsr_in[0]), .overrun_i(lsr_in[1]),
    .parity_err_i(lsr_in[2]), .frame_err_i(lsr_in[3]), .break_i(lsr_in[4]),
    .thr_empty_i(lsr_in[5]), .tx_idle_i(lsr_in[6]), .rx_fifo_err_i(lsr_in[7]),
    .status_o(status), .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
    .loop_o(loopb), .rx_flow_o(rx_flow), .word_len_o(word_len),
    .two_stop_o(two_stop), .parity_en_o(par_en), .parity_even_o(par_even)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d; step(); cfg_we = 1'b0;
  endtask

  task automatic rd();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [3:0] exp;
    logic [3:0] lv;
    repeat (3) step();
    // R9 reset state
    chk("R9 status", status, 32'h0000_F001);
    chk("R9 cfg outs", {22'h0, rx_flow, loopb, out2, out1, rts, dtr, par_even, par_en, two_stop, word_len},
        32'h0);
    rst_n = 1'b1;
    step();

    // R2 R3 R8: every cause combination against every enable pattern
    for (int en = 0; en < 16; en++) begin
      for (int s = 0; s < 32; s++) begin
        wr_cfg(32'(en));
        lsr_in[1] = s[0]; rx_avail = s[1]; char_tmo = s[2]; tx_space = s[3];
        if (s[4]) mdm_in[0] = ~mdm_in[0];
        step();
        lsr_in[1] = 1'b0;
        if (en[2] && s[0])      exp = {3'd3, 1'b0};
        else if (en[0] && s[1]) exp = {3'd2, 1'b0};
        else if (en[0] && s[2]) exp = {3'd6, 1'b0};
        else if (en[1] && s[3]) exp = {3'd1, 1'b0};
        else if (en[3] && s[4]) exp = {3'd0, 1'b0};
        else                    exp = 4'b0001;
        chk("R2 R3 R8 code", {status[31:24], status[7:0]}, {12'h0, exp});
        rx_avail = 1'b0; char_tmo = 1'b0; tx_space = 1'b0;
        rd();
      end
    end
    wr_cfg(32'h0);
    mdm_in = '0;
    step();
    rd();

    // R4 change flags and inverted levels
    for (int k = 0; k < 4; k++) begin
      mdm_in[k] = 1'b1;
      step();
      lv = 4'(1 << k);
      chk("R4 set", {24'h0, status[15:8]}, {24'h0, ~lv, lv});
      rd();
      chk("R4 cleared", {24'h0, status[15:8]}, {24'h0, ~lv, 4'h0});
      stat_rd = 1'b1; mdm_in[k] = 1'b0; step(); stat_rd = 1'b0;
      chk("R4 change during read", {24'h0, status[15:8]}, {24'h0, 4'hF, lv});
      rd();
      chk("R4 cleared again", {24'h0, status[15:8]}, 32'h0000_00F0);
    end

    // R5 sticky errors
    for (int j = 1; j < 8; j++) begin
      if (j == 5 || j == 6) continue;
      lsr_in[j] = 1'b1; step(); lsr_in[j] = 1'b0;
      repeat (3) step();
      chk("R5 sticky", {24'h0, status[23:16]}, 32'(1 << j));
      rd();
      chk("R5 read clears", {24'h0, status[23:16]}, 32'h0);
      stat_rd = 1'b1; lsr_in[j] = 1'b1; step(); stat_rd = 1'b0; lsr_in[j] = 1'b0;
      chk("R5 pulse during read", {24'h0, status[23:16]}, 32'(1 << j));
      rd();
    end
    // R5 level bits follow inputs
    for (int l = 0; l < 8; l++) begin
      lsr_in = {1'b0, l[2], l[1], 4'b0, l[0]};
      step();
      chk("R5 levels", {24'h0, status[23:16]}, {24'h0, 1'b0, l[2], l[1], 4'b0, l[0]});
    end
    lsr_in = '0;
    step();

    // R6 loopback, R7 modem outputs
    for (int m = 0; m < 16; m++) begin
      mdm_in = ~4'(m);
      wr_cfg(32'((m | 16) << 24));
      step();
      lv = {m[3], m[2], m[0], m[1]};
      chk("R6 loop levels", {28'h0, status[15:12]}, {28'h0, ~lv});
      chk("R7 mctrl outs", {27'h0, loopb, out2, out1, rts, dtr}, 32'(m | 16));
      rd();
      mdm_in = ~mdm_in;
      step();
      chk("R6 external ignored", {24'h0, status[15:8]}, {24'h0, ~lv, 4'h0});
    end
    wr_cfg(32'h0);
    mdm_in = '0;
    step();
    rd();

    // R7 configuration field decode
    for (int i = 0; i < 64; i++) begin
      wr_cfg((32'(i) << 24) | (32'(i[4:0]) << 8));
      chk("R7 mctrl", {26'h0, rx_flow, loopb, out2, out1, rts, dtr}, 32'(i));
      chk("R7 line ctrl", {27'h0, par_even, par_en, two_stop, word_len}, 32'(i[4:0]));
    end
    wr_cfg(32'h0);
    step();
    finish_run();
  end
endmodule